// File: doc/BRIEF.md
# Counter enable set/clear register

This block keeps the enable flags for a group of at most sixteen auxiliary event counters. Software reaches the one shared enable state through two aliased views of a 32-bit register. A write through the set view turns on every counter whose data bit is 1. A write through the clear view turns off every counter whose data bit is 1. In both views a 0 data bit leaves that counter alone. A read through either view returns the same image of the enables.

Each enable output gates the increment of the matching counter. Counter positions at or above the implemented count `IMPL_COUNTERS`, and bits 31 to 16, always read as zero and ignore writes. When the block is built with no counters at all, every access is flagged as undefined and no state changes.

Top module: `cnt_enable_regs`

## Requirements
- R1: After a synchronous active-low reset, `cnt_enable` is all zeros and `acc_rdata` reads 0.
- R2: A write with `acc_clear_view` = 0 (set view) sets each implemented enable bit whose `acc_wdata` bit is 1, and leaves every bit whose data bit is 0 unchanged. `cnt_enable` shows the new value after the next rising clock edge.
- R3: A write with `acc_clear_view` = 1 (clear view) clears each implemented enable bit whose `acc_wdata` bit is 1, and leaves every bit whose data bit is 0 unchanged. The result appears after the next rising edge.
- R4: `acc_rdata[15:0]` continuously equals `cnt_enable`, where bit n is counter n. The value is the same whichever view `acc_clear_view` selects.
- R5: `acc_rdata[31:16]` always reads 0, and `acc_wdata[31:16]` has no effect in either view.
- R6: For n ≥ `IMPL_COUNTERS`, `cnt_enable[n]` and `acc_rdata[n]` stay 0 whatever is written.
- R7: With `IMPL_COUNTERS` = 0, `acc_undef` is 1 in every cycle that `acc_valid` is 1, and no enable changes. With `IMPL_COUNTERS` > 0, `acc_undef` is always 0.
- R8: The enable state changes only in a cycle where `acc_valid` and `acc_write` are both 1. Read accesses and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_clear_view | input | 1 | View select: 0 = set view, 1 = clear view |
| acc_wdata | input | 32 | Write data, one bit per counter |
| acc_rdata | output | 32 | Enable image; bits 31:16 are zero |
| acc_undef | output | 1 | Access is undefined because no counters exist |
| cnt_enable | output | 16 | Per-counter increment enable |

## Verification
Two results come out in the same cycle as the access: `acc_undef`, and `acc_rdata`, which shows the state from before the access. The bench therefore samples both one nanosecond after the negative edge on which it drove the access, before the rising edge that commits the write. `cnt_enable` and the updated `acc_rdata` are due one rising edge after a write. They are sampled at the following negative edge and compared against a bench model that is updated only at that point. Two builds are checked side by side on the same stimulus: one with eleven counters, which sweeps every bit position in both views, and one with no counters, which is checked for the undefined flag and for enables that stay zero.

// File: rtl/cer_pkg.sv
// Package cer_pkg
// Purpose : shared constants and types for the counter enable register.
// Assumes : the architectural register is 32 bits wide, and the enable
//           field occupies its lower sixteen bits.
package cer_pkg;
    localparam int REG_W   = 32;
    localparam int MAX_CNT = 16;

    typedef enum logic {
        VIEW_SET = 1'b0,
        VIEW_CLR = 1'b1
    } view_e;
endpackage

// File: rtl/cer_impl_mask.sv
// Module  cer_impl_mask
// Purpose : derives a constant mask of implemented counter positions, and
//           a flag that tells when no counters exist.
// Assumes : IMPL_COUNTERS lies in 0..MAX_CNT.
module cer_impl_mask
    import cer_pkg::*;
#(
    parameter int IMPL_COUNTERS = 16
) (
    output logic [MAX_CNT-1:0] impl_mask,
    output logic               none_impl
);
    // one mask bit per position, high when that counter exists
    for (genvar i = 0; i < MAX_CNT; i++) begin : g_mask
        assign impl_mask[i] = (i < IMPL_COUNTERS);
    end

    // the whole group is absent when the count is zero
    assign none_impl = (IMPL_COUNTERS == 0);
endmodule

// File: rtl/cer_enable_bank.sv
// Module  cer_enable_bank
// Purpose : holds one enable flop per counter. A qualified write sets or
//           clears each selected implemented bit, according to the view.
// Assumes : wr_en is already qualified (valid, write, counters present).
module cer_enable_bank
    import cer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  view_e              wr_view,
    input  logic [MAX_CNT-1:0] wr_bits,
    input  logic [MAX_CNT-1:0] impl_mask,
    output logic [MAX_CNT-1:0] en_q
);
    logic [MAX_CNT-1:0] hit;

    // bits that a write would touch this cycle
    assign hit = wr_bits & impl_mask;

    for (genvar i = 0; i < MAX_CNT; i++) begin : g_bit
        // per-bit flop: reset to off; a selected bit takes the view's value
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[i] <= 1'b0;
            else if (wr_en && hit[i])
                en_q[i] <= (wr_view == VIEW_SET);
        end
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == VIEW_SET) |=> ((en_q & $past(hit)) == $past(hit)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == VIEW_CLR) |=> ((en_q & $past(hit)) == '0));

    p_zero_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((en_q ^ $past(en_q)) & ~$past(wr_bits)) == '0));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));
endmodule

// File: rtl/cer_read_view.sv
// Module  cer_read_view
// Purpose : forms the 32-bit read image shared by both views, and raises
//           the undefined flag on any access when no counters exist.
// Assumes : en_q already holds zero in unimplemented positions.
module cer_read_view
    import cer_pkg::*;
(
    input  logic [MAX_CNT-1:0] en_q,
    input  logic               none_impl,
    input  logic               acc_valid,
    output logic [REG_W-1:0]   rdata,
    output logic               undef
);
    // zero-extend the enable field; reserved upper bits read as zero
    always_comb begin
        rdata              = '0;
        rdata[MAX_CNT-1:0] = en_q;
    end

    // every access is undefined when the group is absent
    assign undef = acc_valid && none_impl;
endmodule

// File: rtl/cnt_enable_regs.sv
// Module  cnt_enable_regs
// Purpose : top of the counter enable register, with set and clear aliased
//           views of one shared enable state.
// Assumes : at most one access per cycle; access permission is checked
//           upstream.
module cnt_enable_regs
    import cer_pkg::*;
#(
    parameter int IMPL_COUNTERS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_clear_view,
    input  logic [REG_W-1:0]   acc_wdata,
    output logic [REG_W-1:0]   acc_rdata,
    output logic               acc_undef,
    output logic [MAX_CNT-1:0] cnt_enable
);
    logic [MAX_CNT-1:0] impl_mask;
    logic               none_impl;
    logic               wr_en;
    logic               unused_rsvd;

    // the reserved write bits have no destination
    assign unused_rsvd = ^acc_wdata[REG_W-1:MAX_CNT];

    // a write commits only when valid and counters exist
    assign wr_en = acc_valid && acc_write && !none_impl;

    cer_impl_mask #(.IMPL_COUNTERS(IMPL_COUNTERS)) u_mask (
        .impl_mask (impl_mask),
        .none_impl (none_impl)
    );

    cer_enable_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_view   (view_e'(acc_clear_view)),
        .wr_bits   (acc_wdata[MAX_CNT-1:0]),
        .impl_mask (impl_mask),
        .en_q      (cnt_enable)
    );

    cer_read_view u_read (
        .en_q      (cnt_enable),
        .none_impl (none_impl),
        .acc_valid (acc_valid),
        .rdata     (acc_rdata),
        .undef     (acc_undef)
    );

    p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_enable & ~impl_mask) == '0));

    p_undef_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_undef |=> $stable(cnt_enable));

    p_read_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rdata[MAX_CNT-1:0] == cnt_enable));
endmodule

// File: tb/test_cnt_enable_regs.sv
module test_cnt_enable_regs;
    localparam int NCNT = 11;
    localparam logic [31:0] MASK = (32'd1 << NCNT) - 32'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_clear_view = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rdata_a, rdata_z;
    logic        undef_a, undef_z;
    logic [15:0] en_a, en_z;

    int          nchk = 0;
    int          nfail = 0;
    logic [31:0] exp_en = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    cnt_enable_regs #(.IMPL_COUNTERS(NCNT)) i_cnt_enable_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_clear_view(acc_clear_view), .acc_wdata(acc_wdata),
        .acc_rdata(rdata_a), .acc_undef(undef_a), .cnt_enable(en_a));

    cnt_enable_regs #(.IMPL_COUNTERS(0)) i_cnt_enable_regs_none (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_clear_view(acc_clear_view), .acc_wdata(acc_wdata),
        .acc_rdata(rdata_z), .acc_undef(undef_z), .cnt_enable(en_z));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one access; checks same-cycle results, then post-edge state
    task automatic access(input logic vld, input logic wr, input logic clr,
                          input logic [31:0] d, input string tag);
        @(negedge clk);
        acc_valid = vld; acc_write = wr; acc_clear_view = clr; acc_wdata = d;
        #1;
        chk("R7 undef with counters", {31'd0, undef_a}, 32'd0);
        chk("R7 undef without counters", {31'd0, undef_z}, {31'd0, vld});
        chk("R4 read before commit", rdata_a, exp_en);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        if (vld && wr) begin
            if (clr) exp_en = exp_en & ~(d & MASK);
            else     exp_en = exp_en | (d & MASK);
        end
        #1;
        chk(tag, {16'd0, en_a}, exp_en);
        chk("R4 read image", rdata_a, exp_en);
        chk("R7 no state without counters", {16'd0, en_z}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset enables", {16'd0, en_a}, 32'd0);
        chk("R1 reset read", rdata_a, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int b = 0; b < 32; b++)
            access(1'b1, 1'b1, 1'b0, 32'd1 << b, "R2 R5 R6 set single bit");
        access(1'b1, 1'b0, 1'b1, 32'h0, "R4 read via clear view");
        access(1'b1, 1'b0, 1'b0, 32'h0, "R4 read via set view");
        access(1'b1, 1'b1, 1'b0, 32'h0, "R2 zero data in set view keeps");
        access(1'b1, 1'b1, 1'b1, 32'h0, "R3 zero data in clear view keeps");
        access(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, "R8 read access no change");
        access(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8 invalid write no change");
        for (int b = 31; b >= 0; b--)
            access(1'b1, 1'b1, 1'b1, 32'd1 << b, "R3 R5 clear single bit");
        access(1'b1, 1'b1, 1'b0, 32'hFFFF_0000, "R5 reserved set ignored");
        for (int k = 0; k < 300; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            access(lfsr[31] | lfsr[30], lfsr[29] | lfsr[28], lfsr[27], lfsr,
                   "R2 R3 R6 R8 mixed pattern");
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule